// File: doc/BRIEF.md
# Single-Loop Second-Order Digital Noise-Shaping Modulator

This block turns a stream of signed 16-bit samples into a one-bit density stream. The one-bit stream's quantization error is pushed out of the low band with a second-order high-pass shape. Only one feedback loop is used. A single recursive loop filter holds two past loop-state words and one past error word. Its combined recurrence gives a noise transfer of (1 − z⁻¹)² and a signal transfer of 2z⁻¹ − z⁻².

Each accepted sample is scaled down by an arithmetic right shift, which keeps headroom in the state. The previous decision, fed back at a fixed two-level magnitude, is subtracted from it. The result drives the loop recurrence. A zero-threshold quantizer then yields the next bit. The bit stream is meant to feed a decimating low-pass filter elsewhere on the chip. Cycles without a valid sample leave the loop frozen.

Top module: `dsm2_single_loop`

## Requirements
- R1: A synchronous active-high reset clears both stored loop-state words and the stored error word. It sets the stored decision to −1 (`outBit` = 0) and drives `outValid` low.
- R2: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high outside reset, and low otherwise.
- R3: The accepted sample is sign-extended and arithmetically shifted right by `SHIFT` (default 2) before use, so xs = floor(inSample / 4).
- R4: The error word is e = xs − 2·F·d, where F = 2^(15−SHIFT) (8192 by default). Here d is +1 when the stored decision bit is 1 and −1 when it is 0.
- R5: The loop state follows q = 2·q₁ − q₂ + 2·e − e₁, with q₁, q₂ the two previous states and e₁ the previous error. It is held in 24-bit signed words, and a result beyond the 24-bit range clamps to the nearest extreme.
- R6: The new decision bit is 1 (+1) when q > 0 and 0 (−1) when q ≤ 0. After reset, three zero samples therefore give the bits 1, 1, 0.
- R7: In cycles with `inValid` low, the state, the error word and `outBit` keep their values. A later sample continues the sequence as if no gap had occurred.
- R8: For a constant input, the sum of the ±1 outputs over N samples, times 2F, stays within 8·2F of N·xs. In other words, the bit density tracks the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe |
| inSample | input | 16 | Two's-complement input sample |
| outValid | output | 1 | High when `outBit` carries a new decision |
| outBit | output | 1 | Current decision: 1 means +1, 0 means −1 |

## Verification
Each accepted sample produces its decision one rising edge later, together with `outValid`. The driver therefore pushes the model's bit into a queue when it presents a sample. The monitor pops that bit on the falling edge that follows, whenever `outValid` is high. Because of this, idle gaps and back-to-back samples need no special handling in the compare. During gaps the monitor confirms that `outValid` stays low and that `outBit` does not move. Density is judged on the full run of outputs for each constant input.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int DSM_IN_W  = 16;
  localparam int DSM_SHIFT = 2;
  localparam int DSM_ACC_W = 24;

  typedef struct packed {
    logic load;   // advance the loop by one sample
    logic clear;  // return the loop to its reset state
  } dsmStrobe_t;
endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output dsmStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R2: a decision is flagged exactly one cycle after each accepted sample
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int IN_W  = DSM_IN_W,
  parameter int SHIFT = DSM_SHIFT,
  parameter int ACC_W = DSM_ACC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  dsmStrobe_t      strobe,
  input  logic [IN_W-1:0] inSample,
  output logic            outBit
);
  localparam int WIDE = ACC_W + 3;
  localparam logic signed [ACC_W-1:0] FB_POS = ACC_W'(2 * (1 << (IN_W - 1 - SHIFT)));
  localparam logic signed [WIDE-1:0]  Q_MAX  = (WIDE'(1) <<< (ACC_W - 1)) - WIDE'(1);
  localparam logic signed [WIDE-1:0]  Q_MIN  = -(WIDE'(1) <<< (ACC_W - 1));

  logic signed [ACC_W-1:0] qPrev1, qPrev2, errPrev;
  logic signed [ACC_W-1:0] xExt, xScaled, fbVal, errNow, qNext;
  logic signed [WIDE-1:0]  qSum;
  logic                    bitNow;

  // scale the sample down to leave headroom in the loop words
  always_comb begin
    xExt    = {{(ACC_W - IN_W){inSample[IN_W-1]}}, inSample};
    xScaled = xExt >>> SHIFT;
    fbVal   = outBit ? FB_POS : -FB_POS;
    errNow  = xScaled - fbVal;
  end

  // combined second-order recurrence, computed wide and clamped
  always_comb begin
    qSum = (WIDE'(qPrev1) <<< 1) - WIDE'(qPrev2)
         + (WIDE'(errNow) <<< 1) - WIDE'(errPrev);
    if (qSum > Q_MAX)      qNext = ACC_W'(Q_MAX);
    else if (qSum < Q_MIN) qNext = ACC_W'(Q_MIN);
    else                   qNext = ACC_W'(qSum);
    bitNow = !qNext[ACC_W-1] && (qNext != '0);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      qPrev1  <= '0;
      qPrev2  <= '0;
      errPrev <= '0;
      outBit  <= 1'b0;
    end else if (strobe.load) begin
      qPrev1  <= qNext;
      qPrev2  <= qPrev1;
      errPrev <= errNow;
      outBit  <= bitNow;
    end
  end

  // R1: reset leaves the decision at -1
  p_reset_bit_r1: assert property (@(posedge clk)
    rst |=> !outBit);
  // R7: idle cycles freeze the loop
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> ($stable(qPrev1) && $stable(qPrev2) && $stable(errPrev) && $stable(outBit)));
  // R5: the older state word is the previous newer one
  p_state_shift_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (qPrev2 == $past(qPrev1)));
  // R6: the stored decision agrees with the sign of the stored state
  p_decision_sign_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (outBit == (!qPrev1[ACC_W-1] && (qPrev1 != '0))));
endmodule

// File: rtl/dsm2_single_loop.sv
module dsm2_single_loop
  import dsm_pkg::*;
#(
  parameter int IN_W  = DSM_IN_W,
  parameter int SHIFT = DSM_SHIFT,
  parameter int ACC_W = DSM_ACC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [IN_W-1:0] inSample,
  output logic            outValid,
  output logic            outBit
);
  dsmStrobe_t strobe;

  dsm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  dsm_datapath #(.IN_W(IN_W), .SHIFT(SHIFT), .ACC_W(ACC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inSample (inSample),
    .outBit   (outBit)
  );
endmodule

// File: tb/dsm2_single_loop_tb.sv
`timescale 1ns/1ps
module dsm2_single_loop_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic        outValid, outBit;

  always #4 clk = ~clk;

  dsm2_single_loop u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outBit(outBit)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit expQ[$];
  longint mq1, mq2, me1;
  bit     my;
  longint sumY;
  int     nOut;

  localparam longint FB2  = 16384;
  localparam longint QMAX = (64'sd1 <<< 23) - 1;
  localparam longint QMIN = -(64'sd1 <<< 23);

  task automatic check(input string req, input longint act, input longint expv, input string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference recurrence from R3..R6
  task automatic modelStep(input logic signed [15:0] x, output bit b);
    longint xs, e, q;
    xs = longint'(x) >>> 2;
    e  = xs - (my ? FB2 : -FB2);
    q  = 2*mq1 - mq2 + 2*e - me1;
    if (q > QMAX) q = QMAX;
    if (q < QMIN) q = QMIN;
    mq2 = mq1; mq1 = q; me1 = e;
    my = (q > 0);
    b = my;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", outValid, 0, "outValid in reset");
    check("R1", outBit, 0, "outBit in reset");
    rst = 1'b0;
    mq1 = 0; mq2 = 0; me1 = 0; my = 0;
    expQ.delete();
    sumY = 0; nOut = 0;
  endtask

  task automatic sendSample(input logic signed [15:0] x);
    bit b;
    @(negedge clk);
    inValid = 1'b1;
    inSample = x;
    modelStep(x, b);
    expQ.push_back(b);
  endtask

  task automatic drain();
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", expQ.size(), 0, "outputs still owed");
  endtask

  // monitor: compare each decision in the cycle after its sample (R2, R5)
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) check("R2", 1, 0, "unexpected outValid");
      else check("R5", outBit, expQ.pop_front(), "decision vs model");
      sumY += outBit ? 1 : -1;
      nOut++;
    end
  end

  task automatic densityRun(input logic signed [15:0] x, input int n);
    longint diff;
    doReset();
    for (int i = 0; i < n; i++) sendSample(x);
    drain();
    diff = sumY * FB2 - longint'(n) * (longint'(x) >>> 2);
    if (diff < 0) diff = -diff;
    check("R8", (diff <= 8 * FB2) ? 1 : 0, 1, "density error within bound");
    check("R8", nOut, n, "output count");
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit prevBit;

    // R1 and R6: zero input from reset gives 1,1,0
    doReset();
    @(negedge clk);
    check("R2", outValid, 0, "outValid after reset release");
    for (int i = 0; i < 3; i++) sendSample(16'sd0);
    drain();

    doReset();
    sendSample(16'sd0);
    @(negedge clk); inValid = 1'b0;
    check("R6", outBit, 1, "first decision for zero");
    sendSample(16'sd0);
    @(negedge clk); inValid = 1'b0;
    check("R6", outBit, 1, "second decision for zero");
    sendSample(16'sd0);
    @(negedge clk); inValid = 1'b0;
    check("R6", outBit, 0, "third decision for zero");
    drain();

    // R3: truncating shift, small values
    doReset();
    for (int i = -8; i < 8; i++) sendSample(16'(i * 3));
    drain();

    // R4, R5: sawtooth across the full range
    doReset();
    for (int i = 0; i < 600; i++) sendSample(16'((i * 1237) & 16'hFFFF));
    drain();

    // R5: extremes alternating
    doReset();
    for (int i = 0; i < 200; i++) sendSample((i % 2) ? 16'sh7FFF : 16'sh8000);
    drain();

    // R7: pseudo-random with idle gaps
    doReset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendSample(lfsr);
      if (i % 37 == 36) begin
        @(negedge clk); inValid = 1'b0;
        prevBit = outBit;
        repeat (4) begin
          @(negedge clk);
          check("R7", outValid, 0, "outValid in gap");
          check("R7", outBit, prevBit, "outBit held in gap");
        end
      end
    end
    drain();

    // R8: density for several constant inputs
    densityRun(16'sd8192, 2048);
    densityRun(-16'sd20000, 2048);
    densityRun(16'sd32767, 2048);
    densityRun(-16'sd32768, 2048);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule